// File: doc/BRIEF.md
# Character Display Power-On Sequencer

This block runs on the host side of a character display controller. It brings the controller up after power-on through a 4-bit command port. Each byte goes out as two write strobes, upper nibble first. A separate address-select level tells the controller whether the byte is a command or data. Before every byte the sequencer either polls the controller's busy flag with a read strobe or, when polling is disabled at elaboration, waits a fixed number of cycles.

The byte stream is fixed at elaboration time. It starts with a controller reset and a line-count selection. It then fills the display memory with the blank character and loads a set of user glyphs into the character-generator memory, each glyph as one address command followed by eight row bytes. It finishes with six cursor and display settings. A done flag then stays high until the next reset. A busy flag that never clears stops the sequence and raises an error flag that also stays high.

Top module: `lcd_init_seq`

## Requirements
- R1: While `rst_n` is low, `lcd_rd`, `lcd_wr`, `lcd_a0`, `lcd_dout`, `seq_done` and `seq_err` are all 0. On the first clock edge after release, the block starts the gate (poll or wait) for byte 0.
- R2: Each byte takes two consecutive `lcd_wr` cycles, upper nibble first, with the same `lcd_a0` level in both. The busy flag is not sampled between the two nibbles, so a busy flag raised during the upper nibble does not delay the lower one.
- R3: With polling enabled, every byte starts with `lcd_rd` high and `lcd_a0` low. `lcd_din[3]` = 1 means busy, and the read is repeated. The upper nibble is written in the cycle after a read that saw `lcd_din[3]` = 0. Bits 2:0 of `lcd_din` are ignored. `lcd_rd` and `lcd_wr` are never high together.
- R4: The first two bytes are commands (`lcd_a0` = 0): controller reset 0x01, then line select 0x20 OR `TWO_LINE`.
- R5: Next come `CLR_LEN` data bytes (`lcd_a0` = 1), each holding the blank code 0x20.
- R6: For each glyph p from 0 to `NGLYPH`-1 there is a command 0x40 OR (p*8), then eight data bytes. Row r has the value ((8p + r) * 7) mod 32.
- R7: Six commands close the sequence, in this order: display 0x30 OR `DISP_ON`, cursor address 0x80 OR (`CUR_ADDR` mod 128), direction 0x34 OR `CUR_DIR`, font 0x38 OR `CUR_UL`, blink 0x3A OR `CUR_BLINK`, cursor enable 0x3C OR `CUR_ON`.
- R8: `seq_done` goes high in the cycle after the last lower nibble. It stays high with no further strobes until reset.
- R9: If `BUSY_TMO` reads in a row for one byte all see busy, `seq_err` goes high in the next cycle. It stays high with no strobes, and `seq_done` stays 0. `BUSY_TMO`-1 busy reads followed by a free one let the sequence continue.
- R10: With `POLL_EN` = 0, `lcd_rd` never goes high and the busy flag is ignored. Exactly `WAIT_CYC` idle cycles come before every byte's upper nibble, and the byte stream is the same as with polling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lcd_din | input | 4 | Read-back from the controller; bit 3 is the busy flag |
| lcd_dout | output | 4 | Nibble being written; 0 when not writing |
| lcd_a0 | output | 1 | 0 = command byte, 1 = data byte; 0 outside writes |
| lcd_wr | output | 1 | Write strobe, high for one cycle per nibble |
| lcd_rd | output | 1 | Busy-flag read strobe |
| seq_done | output | 1 | Sequence complete, sticky |
| seq_err | output | 1 | Busy timeout, sticky |

## Verification
The polled instance is run three times. The first run gives each byte a different number of busy reads, including one byte with one read short of the timeout. This separates a correct retry count from an off-by-one limit, and separates nibble order from busy handling. The second run holds busy past the limit on one byte, which shows the error path and that both flags are sticky. The third run never asserts busy, and shows that the stream and the done timing hold without any wait. A second instance with polling disabled has its busy flag tied high, which shows the fixed wait length and that the flag is ignored in that mode.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  typedef enum logic [2:0] {
    ST_START,
    ST_GATE,
    ST_HI,
    ST_LO,
    ST_DONE,
    ST_ERR
  } seq_state_e;

  typedef struct packed {
    logic       a0;
    logic [7:0] code;
  } bus_byte_t;

  localparam logic [7:0] OP_RESET   = 8'h01;
  localparam logic [7:0] OP_LINES   = 8'h20;
  localparam logic [7:0] BLANK_CODE = 8'h20;
  localparam logic [7:0] OP_CGADDR  = 8'h40;
  localparam logic [7:0] OP_DISP    = 8'h30;
  localparam logic [7:0] OP_CURADDR = 8'h80;
  localparam logic [7:0] OP_CURDIR  = 8'h34;
  localparam logic [7:0] OP_FONT    = 8'h38;
  localparam logic [7:0] OP_BLINK   = 8'h3A;
  localparam logic [7:0] OP_CURSOR  = 8'h3C;

  localparam int unsigned GLYPH_ROWS = 8;
  localparam int unsigned CFG_CMDS   = 6;

  // Row pattern of a user glyph.
  function automatic logic [7:0] glyph_row(int unsigned p, int unsigned r);
    int unsigned v;
    v = ((p * GLYPH_ROWS + r) * 7) % 32;
    return 8'(v);
  endfunction

  // Number of bytes sent over the whole sequence.
  function automatic int unsigned step_total(int unsigned clr, int unsigned nglyph);
    return 2 + clr + nglyph * (GLYPH_ROWS + 1) + CFG_CMDS;
  endfunction

endpackage

// File: rtl/lcd_init_steprom.sv
module lcd_init_steprom
  import lcd_init_pkg::*;
#(
  parameter int unsigned CLR_LEN   = 16,
  parameter int unsigned NGLYPH    = 2,
  parameter bit          TWO_LINE  = 1'b1,
  parameter bit          DISP_ON   = 1'b1,
  parameter int unsigned CUR_ADDR  = 5,
  parameter bit          CUR_DIR   = 1'b1,
  parameter bit          CUR_UL    = 1'b0,
  parameter bit          CUR_BLINK = 1'b1,
  parameter bit          CUR_ON    = 1'b1,
  parameter int          IDX_W     = 6
) (
  input  logic [IDX_W-1:0] idx,
  output bus_byte_t        item,
  output logic             last
);
  localparam int unsigned NSTEP = step_total(CLR_LEN, NGLYPH);
  localparam int unsigned CG0   = 2 + CLR_LEN;
  localparam int unsigned CFG0  = CG0 + NGLYPH * (GLYPH_ROWS + 1);

  int unsigned s;
  int unsigned off;
  int unsigned gl;
  int unsigned rw;

  always_comb begin
    s    = 32'(idx);
    off  = 0;
    gl   = 0;
    rw   = 0;
    item = '{a0: 1'b0, code: 8'h00};
    if (s == 0) begin
      item.code = OP_RESET;
    end else if (s == 1) begin
      item.code = OP_LINES | {7'd0, TWO_LINE};
    end else if (s < CG0) begin
      item.a0   = 1'b1;
      item.code = BLANK_CODE;
    end else if (s < CFG0) begin
      off = s - CG0;
      gl  = off / (GLYPH_ROWS + 1);
      rw  = off % (GLYPH_ROWS + 1);
      if (rw == 0) begin
        item.code = OP_CGADDR | 8'(gl * GLYPH_ROWS);
      end else begin
        item.a0   = 1'b1;
        item.code = glyph_row(gl, rw - 1);
      end
    end else begin
      case (s - CFG0)
        0:       item.code = OP_DISP    | {7'd0, DISP_ON};
        1:       item.code = OP_CURADDR | 8'(CUR_ADDR % 128);
        2:       item.code = OP_CURDIR  | {7'd0, CUR_DIR};
        3:       item.code = OP_FONT    | {7'd0, CUR_UL};
        4:       item.code = OP_BLINK   | {7'd0, CUR_BLINK};
        default: item.code = OP_CURSOR  | {7'd0, CUR_ON};
      endcase
    end
    last = (s == NSTEP - 1);
  end

endmodule

// File: rtl/lcd_init_gate.sv
module lcd_init_gate #(
  parameter bit          POLL_EN  = 1'b1,
  parameter int unsigned BUSY_TMO = 8,
  parameter int unsigned WAIT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic busy,
  output logic rd_o,
  output logic pass_o,
  output logic tmo_o
);
  localparam int unsigned LIM = POLL_EN ? BUSY_TMO : WAIT_CYC;
  localparam int          CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt;
  logic          at_lim;

  assign at_lim = (cnt == CW'(LIM - 1));

  generate
    if (POLL_EN) begin : g_poll
      assign rd_o   = arm;
      assign pass_o = arm & ~busy;
      assign tmo_o  = arm & busy & at_lim;
      always_ff @(posedge clk) begin
        if (!rst_n || !arm) cnt <= '0;
        else if (busy)      cnt <= cnt + 1'b1;
      end
    end else begin : g_wait
      logic unused_busy;
      assign unused_busy = busy;
      assign rd_o   = 1'b0;
      assign pass_o = arm & at_lim;
      assign tmo_o  = 1'b0;
      always_ff @(posedge clk) begin
        if (!rst_n || !arm) cnt <= '0;
        else if (!at_lim)   cnt <= cnt + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter int unsigned CLR_LEN   = 16,
  parameter int unsigned NGLYPH    = 2,
  parameter bit          TWO_LINE  = 1'b1,
  parameter bit          DISP_ON   = 1'b1,
  parameter int unsigned CUR_ADDR  = 5,
  parameter bit          CUR_DIR   = 1'b1,
  parameter bit          CUR_UL    = 1'b0,
  parameter bit          CUR_BLINK = 1'b1,
  parameter bit          CUR_ON    = 1'b1,
  parameter bit          POLL_EN   = 1'b1,
  parameter int unsigned BUSY_TMO  = 8,
  parameter int unsigned WAIT_CYC  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] lcd_din,
  output logic [3:0] lcd_dout,
  output logic       lcd_a0,
  output logic       lcd_wr,
  output logic       lcd_rd,
  output logic       seq_done,
  output logic       seq_err
);
  localparam int unsigned NSTEP    = step_total(CLR_LEN, NGLYPH);
  localparam int          IDX_W    = $clog2(NSTEP);
  localparam int          BUSY_BIT = 3;

  seq_state_e       state, state_nx;
  logic [IDX_W-1:0] step;
  bus_byte_t        item;
  logic             item_last;
  logic             gate_rd, gate_pass, gate_tmo;

  // Named events for the checker
  logic ev_byte_sent;
  logic ev_busy_seen;
  logic unused_din;

  assign unused_din = ^lcd_din[2:0];

  lcd_init_steprom #(
    .CLR_LEN(CLR_LEN), .NGLYPH(NGLYPH), .TWO_LINE(TWO_LINE), .DISP_ON(DISP_ON),
    .CUR_ADDR(CUR_ADDR), .CUR_DIR(CUR_DIR), .CUR_UL(CUR_UL),
    .CUR_BLINK(CUR_BLINK), .CUR_ON(CUR_ON), .IDX_W(IDX_W)
  ) u_rom (
    .idx  (step),
    .item (item),
    .last (item_last)
  );

  lcd_init_gate #(
    .POLL_EN(POLL_EN), .BUSY_TMO(BUSY_TMO), .WAIT_CYC(WAIT_CYC)
  ) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (state == ST_GATE),
    .busy   (lcd_din[BUSY_BIT]),
    .rd_o   (gate_rd),
    .pass_o (gate_pass),
    .tmo_o  (gate_tmo)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_START: state_nx = ST_GATE;
      ST_GATE: begin
        if (gate_tmo)       state_nx = ST_ERR;
        else if (gate_pass) state_nx = ST_HI;
      end
      ST_HI:   state_nx = ST_LO;
      ST_LO:   state_nx = item_last ? ST_DONE : ST_GATE;
      default: state_nx = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_START;
      step  <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_LO && !item_last) step <= step + 1'b1;
    end
  end

  assign ev_byte_sent = (state == ST_LO);
  assign ev_busy_seen = gate_rd & lcd_din[BUSY_BIT];

  assign lcd_rd   = gate_rd;
  assign lcd_wr   = (state == ST_HI) || (state == ST_LO);
  assign lcd_a0   = lcd_wr & item.a0;
  assign lcd_dout = (state == ST_HI) ? item.code[7:4] :
                    (state == ST_LO) ? item.code[3:0] : 4'h0;
  assign seq_done = (state == ST_DONE);
  assign seq_err  = (state == ST_ERR);

endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk #(
  parameter bit POLL_EN = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_bit,
  input logic [3:0] lcd_dout,
  input logic       lcd_a0,
  input logic       lcd_wr,
  input logic       lcd_rd,
  input logic       seq_done,
  input logic       seq_err,
  input logic       ev_byte_sent,
  input logic       ev_busy_seen
);
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !lcd_wr |-> (lcd_dout == 4'h0) && !lcd_a0); // R1
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(lcd_rd && lcd_wr)); // R3
  AST_NIBBLE_PAIR: assert property (@(posedge clk) disable iff (!rst_n) $rose(lcd_wr) |=> lcd_wr && $stable(lcd_a0)); // R2
  AST_PAIR_ENDS: assert property (@(posedge clk) disable iff (!rst_n) (lcd_wr && $past(lcd_wr)) |=> !lcd_wr); // R2
  AST_WRITE_AFTER_FREE: assert property (@(posedge clk) disable iff (!rst_n) (POLL_EN && $rose(lcd_wr)) |-> ($past(lcd_rd) && !$past(busy_bit))); // R3
  AST_BUSY_REPOLL: assert property (@(posedge clk) disable iff (!rst_n) ev_busy_seen |=> (lcd_rd || seq_err)); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) seq_done |=> seq_done); // R8
  AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n) $rose(seq_done) |-> $past(ev_byte_sent)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) seq_err |=> seq_err && !seq_done); // R9
  AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (seq_done || seq_err) |-> !lcd_rd && !lcd_wr); // R8
endmodule

bind lcd_init_seq lcd_init_seq_chk #(.POLL_EN(POLL_EN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy_bit     (lcd_din[3]),
  .lcd_dout     (lcd_dout),
  .lcd_a0       (lcd_a0),
  .lcd_wr       (lcd_wr),
  .lcd_rd       (lcd_rd),
  .seq_done     (seq_done),
  .seq_err      (seq_err),
  .ev_byte_sent (ev_byte_sent),
  .ev_busy_seen (ev_busy_seen)
);

// File: tb/tb_lcd_init_seq.sv
module tb_lcd_init_seq;
  localparam int CLR  = 16;
  localparam int NG   = 2;
  localparam int TMO  = 8;
  localparam int WAIT = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [3:0] lcd_din = 4'h8;
  logic [3:0] lcd_dout;
  logic       lcd_a0, lcd_wr, lcd_rd, seq_done, seq_err;

  logic       rst_w_n = 1'b0;
  logic [3:0] w_din;
  logic [3:0] w_dout;
  logic       w_a0, w_wr, w_rd, w_done, w_err;
  assign w_din = 4'h8;

  int nchk = 0;
  int nerr = 0;
  byte unsigned exp_code[$];
  bit           exp_a0[$];

  lcd_init_seq dut (
    .clk(clk), .rst_n(rst_n), .lcd_din(lcd_din), .lcd_dout(lcd_dout),
    .lcd_a0(lcd_a0), .lcd_wr(lcd_wr), .lcd_rd(lcd_rd),
    .seq_done(seq_done), .seq_err(seq_err)
  );

  lcd_init_seq #(.POLL_EN(1'b0), .WAIT_CYC(WAIT)) dut_w (
    .clk(clk), .rst_n(rst_w_n), .lcd_din(w_din), .lcd_dout(w_dout),
    .lcd_a0(w_a0), .lcd_wr(w_wr), .lcd_rd(w_rd),
    .seq_done(w_done), .seq_err(w_err)
  );

  function automatic logic [8:0] pk(bit rd, bit wr, bit a0, logic [3:0] d, bit dn, bit er);
    return {rd, wr, a0, d, dn, er};
  endfunction

  function automatic string tag_of(int i);
    if (i < 2) return "R4";
    if (i < 2 + CLR) return "R5";
    if (i < 2 + CLR + 9 * NG) return "R6";
    return "R7";
  endfunction

  task automatic push(bit a0, int code);
    exp_a0.push_back(a0);
    exp_code.push_back(byte'(code));
  endtask

  task automatic build_list;
    push(0, 8'h01);
    push(0, 8'h21);
    for (int i = 0; i < CLR; i++) push(1, 8'h20);
    for (int p = 0; p < NG; p++) begin
      push(0, 8'h40 + p * 8);
      for (int r = 0; r < 8; r++) push(1, ((p * 8 + r) * 7) % 32);
    end
    push(0, 8'h31); push(0, 8'h85); push(0, 8'h35);
    push(0, 8'h38); push(0, 8'h3B); push(0, 8'h3D);
  endtask

  task automatic check_bus(string tag, logic [8:0] exp);
    logic [8:0] obs;
    obs = {lcd_rd, lcd_wr, lcd_a0, lcd_dout, seq_done, seq_err};
    nchk++;
    if (obs !== exp) begin
      nerr++;
      $display("FAIL %s actual={rd,wr,a0,d,done,err}=%b expected=%b", tag, obs, exp);
    end
  endtask

  task automatic check_val(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset;
    rst_n   = 1'b0;
    lcd_din = 4'h8;
    repeat (3) @(negedge clk);
    check_bus("R1 reset", pk(0, 0, 0, 4'h0, 0, 0));
    rst_n = 1'b1;
  endtask

  // mode 0: never busy; mode 1: varied busy counts. stop_at: byte held busy past the limit.
  task automatic run_seq(int mode, int stop_at);
    for (int i = 0; i < exp_code.size(); i++) begin
      int nb;
      logic [7:0] c;
      c  = exp_code[i];
      nb = (mode == 1) ? ((i == 3) ? TMO - 1 : i % 3) : 0;
      if (i == stop_at) nb = TMO;
      for (int k = 0; k <= nb; k++) begin
        @(negedge clk);
        check_bus("R3 poll", pk(1, 0, 0, 4'h0, 0, 0));
        lcd_din = (k < nb) ? 4'hF : 4'h7;
        if (k < nb && k == TMO - 1) begin
          for (int e = 0; e < 12; e++) begin
            @(negedge clk);
            check_bus("R9 timeout", pk(0, 0, 0, 4'h0, 0, 1));
            lcd_din = 4'h0;
          end
          return;
        end
      end
      @(negedge clk);
      check_bus({tag_of(i), " R2 high nibble"}, pk(0, 1, exp_a0[i], c[7:4], 0, 0));
      lcd_din = 4'h8;
      @(negedge clk);
      check_bus({tag_of(i), " R2 low nibble"}, pk(0, 1, exp_a0[i], c[3:0], 0, 0));
      lcd_din = 4'h8;
    end
    for (int d = 0; d < 6; d++) begin
      @(negedge clk);
      check_bus("R8 done", pk(0, 0, 0, 4'h0, 1, 0));
    end
  endtask

  task automatic run_wait_mode;
    rst_w_n = 1'b0;
    repeat (3) @(negedge clk);
    check_val("R1 reset wait-mode outputs", {w_rd, w_wr, w_a0, w_dout, w_done, w_err}, 0);
    rst_w_n = 1'b1;
    for (int i = 0; i < exp_code.size(); i++) begin
      int idle;
      logic [7:0] c;
      c    = exp_code[i];
      idle = 0;
      @(negedge clk);
      while (!w_wr && idle < 100) begin
        if (w_rd) check_val("R10 read strobe", 1, 0);
        idle++;
        @(negedge clk);
      end
      check_val("R10 idle gap", idle, WAIT);
      check_val({tag_of(i), " R10 high nibble"}, {w_a0, w_dout}, {exp_a0[i], c[7:4]});
      @(negedge clk);
      check_val({tag_of(i), " R10 low nibble"}, {w_wr, w_a0, w_dout}, {1'b1, exp_a0[i], c[3:0]});
    end
    @(negedge clk);
    check_val("R8 wait-mode done", {w_done, w_err, w_wr, w_rd}, 4'b1000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL R8 watchdog actual=hung expected=sequence end");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    build_list();
    do_reset();
    run_seq(1, -1);
    do_reset();
    run_seq(0, 5);
    do_reset();
    run_seq(0, -1);
    run_wait_mode();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule